// File: doc/BRIEF.md
# Streaming Write Mode Detector

This block sits next to a cache controller and watches the cacheable write requests that miss into it. Each request gives a start address, a byte size and the address of the line it touches. The block decides whether successive writes form one unbroken byte stream. It keeps a running total of the contiguous bytes seen so far.

It moves through three policy modes as the total grows: normal allocation, write coalescing, and coalescing without allocation. It reports the mode to the controller as two flags. When a write breaks the stream, it emits a one-cycle pulse carrying that write's line address, so the controller can drop its per-line delay record for that line.

Requests arrive on a valid/ready channel. Ready is held high at all times, so the block never applies back-pressure, and any cycle with valid high is one accepted request. A separate synchronous mode-clear input returns the detector to its reset state.

Top module: `wstream_mode_det`

## Requirements
- R1: After reset the detector is in allocate mode (coalesce_o=0, allocate_o=1), the contiguous byte count is 0 and the expected next address is 0. A first write starting at address 0 therefore counts as contiguous.
- R2: A write is contiguous when its start address equals the expected next address. After every counted write, the expected next address becomes that write's start address plus its size. A contiguous write adds its size to the byte count.
- R3: Allocate mode changes to coalesce mode when a contiguous write makes the byte count strictly greater than COAL_LINES*LINE_BYTES (128 by default). A count of exactly 128 stays in allocate mode.
- R4: Coalesce mode changes to no-allocate mode when the byte count becomes strictly greater than NOALLOC_LINES*LINE_BYTES (768 by default). A count of exactly 768 stays in coalesce mode. A single write changes the mode by at most one step.
- R5: In no-allocate mode, contiguous writes leave the byte count unchanged and the mode stays no-allocate. The counter saturates and never wraps.
- R6: A non-contiguous counted write loads the byte count with its own size and sets the mode to allocate. One cycle after the request, dly_clr_valid is high for exactly one cycle, with dly_clr_addr equal to that request's line address.
- R7: coalesce_o is 1 in every mode except allocate. allocate_o is 1 in every mode except no-allocate. So allocate is (0,1), coalesce is (1,1) and no-allocate is (1,0).
- R8: A request with req_is_write=0 or req_cacheable=0 changes no state. The flags stay the same, no pulse is emitted, and the expected next address is kept.
- R9: mode_clear=1 at a clock edge sets the allocate mode, a byte count of 0 and an expected next address of 0. It takes priority over a request in the same cycle, and no pulse is emitted for that request.
- R10: The flags and the pulse change on the clock edge that samples the request (one register stage). req_ready is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_ready | output | 1 | Always 1; no back-pressure |
| req_is_write | input | 1 | Request is a write |
| req_cacheable | input | 1 | Request is cacheable |
| req_addr | input | ADDR_W | Start byte address of the write |
| req_size | input | SIZE_W | Write size in bytes |
| req_blk_addr | input | ADDR_W | Line address touched by the write |
| mode_clear | input | 1 | Synchronous return to the reset state |
| coalesce_o | output | 1 | Writes should be coalesced |
| allocate_o | output | 1 | Writes should allocate in the cache |
| dly_clr_valid | output | 1 | One-cycle pulse: clear the delay record |
| dly_clr_addr | output | ADDR_W | Line whose delay record is cleared |

## Verification
A wrong expected next address shows up as a false stream break: an unexpected clear pulse plus a return to allocate one cycle after the write. A missed break shows up as a missing pulse. A count that is off by some bytes moves the mode change one write early or late. The threshold tests sit exactly on each limit and one byte past it, so an error of one byte is visible in the following cycle. Ignored requests and mode-clear collisions are checked by continuing the stream afterwards, which exposes any hidden change to the next address.

// File: rtl/wsd_pkg.sv
package wsd_pkg;
  typedef enum logic [1:0] {
    WM_ALLOC   = 2'd0,
    WM_COAL    = 2'd1,
    WM_NOALLOC = 2'd2
  } wmode_t;
endpackage

// File: rtl/wsd_contig.sv
module wsd_contig #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              clr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  output logic              hit
);
  logic [ADDR_W-1:0] next_q;

  assign hit = (addr == next_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_q <= '0;
    end else if (clr) begin
      next_q <= '0;
    end else if (take) begin
      next_q <= addr + ADDR_W'(size);
    end
  end
endmodule

// File: rtl/wsd_count.sv
module wsd_count #(
  parameter int CNT_W  = 32,
  parameter int SIZE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              hit,
  input  logic              hold,
  input  logic              clr,
  input  logic [SIZE_W-1:0] size,
  output logic [CNT_W-1:0]  cnt_nxt
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   sum;

  always_comb begin
    sum = {1'b0, cnt_q} + (CNT_W+1)'(size);
    if (sum[CNT_W]) cnt_nxt = '1;
    else            cnt_nxt = sum[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (take) begin
      if (!hit)       cnt_q <= CNT_W'(size);
      else if (!hold) cnt_q <= cnt_nxt;
    end
  end
endmodule

// File: rtl/wsd_mode.sv
module wsd_mode
  import wsd_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int COAL_LIM  = 128,
  parameter int NOALC_LIM = 768
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             hit,
  input  logic             clr,
  input  logic [CNT_W-1:0] cnt_nxt,
  output wmode_t           mode_q
);
  localparam logic [CNT_W-1:0] C_LIM = CNT_W'(COAL_LIM);
  localparam logic [CNT_W-1:0] N_LIM = CNT_W'(NOALC_LIM);

  wmode_t mode_d;

  always_comb begin
    mode_d = mode_q;
    if (clr) begin
      mode_d = WM_ALLOC;
    end else if (take) begin
      if (!hit) begin
        mode_d = WM_ALLOC;
      end else begin
        case (mode_q)
          WM_ALLOC: if (cnt_nxt > C_LIM) mode_d = WM_COAL;
          WM_COAL:  if (cnt_nxt > N_LIM) mode_d = WM_NOALLOC;
          default:  mode_d = mode_q;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= WM_ALLOC;
    else        mode_q <= mode_d;
  end
endmodule

// File: rtl/wstream_mode_det.sv
module wstream_mode_det
  import wsd_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int SIZE_W        = 8,
  parameter int CNT_W         = 32,
  parameter int LINE_BYTES    = 64,
  parameter int COAL_LINES    = 2,
  parameter int NOALLOC_LINES = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_is_write,
  input  logic              req_cacheable,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [ADDR_W-1:0] req_blk_addr,
  input  logic              mode_clear,
  output logic              coalesce_o,
  output logic              allocate_o,
  output logic              dly_clr_valid,
  output logic [ADDR_W-1:0] dly_clr_addr
);
  localparam int COAL_LIM  = COAL_LINES * LINE_BYTES;
  localparam int NOALC_LIM = NOALLOC_LINES * LINE_BYTES;

  logic             take;
  logic             hit;
  logic [CNT_W-1:0] cnt_nxt;
  wmode_t           mode_q;

  assign req_ready = 1'b1;
  assign take      = req_valid && req_is_write && req_cacheable;

  wsd_contig #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_contig (
    .clk(clk), .rst_n(rst_n), .take(take), .clr(mode_clear),
    .addr(req_addr), .size(req_size), .hit(hit)
  );

  wsd_count #(.CNT_W(CNT_W), .SIZE_W(SIZE_W)) u_count (
    .clk(clk), .rst_n(rst_n), .take(take), .hit(hit),
    .hold(mode_q == WM_NOALLOC), .clr(mode_clear),
    .size(req_size), .cnt_nxt(cnt_nxt)
  );

  wsd_mode #(.CNT_W(CNT_W), .COAL_LIM(COAL_LIM), .NOALC_LIM(NOALC_LIM)) u_mode (
    .clk(clk), .rst_n(rst_n), .take(take), .hit(hit), .clr(mode_clear),
    .cnt_nxt(cnt_nxt), .mode_q(mode_q)
  );

  assign coalesce_o = (mode_q != WM_ALLOC);
  assign allocate_o = (mode_q != WM_NOALLOC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_clr_valid <= 1'b0;
      dly_clr_addr  <= '0;
    end else begin
      dly_clr_valid <= take && !hit && !mode_clear;
      if (take && !hit && !mode_clear) dly_clr_addr <= req_blk_addr;
    end
  end
endmodule

// File: rtl/wsd_checks.sv
module wsd_checks (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic req_is_write,
  input logic req_cacheable,
  input logic mode_clear,
  input logic coalesce_o,
  input logic allocate_o,
  input logic dly_clr_valid
);
  AST_FLAGS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    coalesce_o || allocate_o); // R7

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !coalesce_o |=> allocate_o); // R4

  AST_BREAK_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    dly_clr_valid |-> (!coalesce_o && allocate_o)); // R6

  AST_IGNORED_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!(req_valid && req_is_write && req_cacheable) && !mode_clear)
      |=> ($stable(coalesce_o) && $stable(allocate_o) && !dly_clr_valid)); // R8

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    mode_clear |=> (!coalesce_o && allocate_o && !dly_clr_valid)); // R9

  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready); // R10
endmodule

bind wstream_mode_det wsd_checks chk_i (.*);

// File: tb/wstream_mode_det_tb_top.sv
module wstream_mode_det_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_is_write = 1'b0, req_cacheable = 1'b0;
  logic [31:0] req_addr = '0, req_blk_addr = '0;
  logic [7:0]  req_size = '0;
  logic        mode_clear = 1'b0;
  logic        req_ready, coalesce_o, allocate_o, dly_clr_valid;
  logic [31:0] dly_clr_addr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    logic        coal;
    logic        alloc;
    logic        clrv;
    logic [31:0] clra;
    string       tag;
  } exp_t;
  exp_t q[$];

  int          m_mode = 0;
  int unsigned m_cnt = 0;
  logic [31:0] m_next = '0;

  always #5 clk = ~clk;

  wstream_mode_det dut_i (.*);

  task automatic chk(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s", tag, msg);
    end
  endtask

  task automatic send(input logic v, input logic wr, input logic ca, input logic clr,
                      input logic [31:0] a, input logic [7:0] sz,
                      input logic [31:0] blk, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = v; req_is_write = wr; req_cacheable = ca; mode_clear = clr;
    req_addr = a; req_size = sz; req_blk_addr = blk;
    @(posedge clk);
    #1;
    req_valid = 0; req_is_write = 0; req_cacheable = 0; mode_clear = 0;
    e.clrv = 0; e.clra = 'x; e.tag = tag;
    if (clr) begin
      m_mode = 0; m_cnt = 0; m_next = '0;
    end else if (v && wr && ca) begin
      if (a == m_next) begin
        if (m_mode != 2) begin
          m_cnt += sz;
          if (m_mode == 0 && m_cnt > 128) m_mode = 1;
          else if (m_mode == 1 && m_cnt > 768) m_mode = 2;
        end
      end else begin
        m_cnt = sz; m_mode = 0; e.clrv = 1; e.clra = blk;
      end
      m_next = a + 32'(sz);
    end
    e.coal = (m_mode != 0);
    e.alloc = (m_mode != 2);
    q.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(coalesce_o === e.coal && allocate_o === e.alloc && dly_clr_valid === e.clrv,
            e.tag, $sformatf("coal/alloc/clr act=%b%b%b exp=%b%b%b",
                             coalesce_o, allocate_o, dly_clr_valid, e.coal, e.alloc, e.clrv));
        if (e.clrv)
          chk(dly_clr_addr === e.clra, e.tag,
              $sformatf("clr addr act=%h exp=%h", dly_clr_addr, e.clra));
        chk(req_ready === 1'b1, "R10", $sformatf("ready act=%b exp=1", req_ready));
      end
    end
  end

  initial begin : watchdog
    #2_000_000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] a;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(coalesce_o === 0 && allocate_o === 1 && dly_clr_valid === 0, "R1",
        $sformatf("reset flags act=%b%b%b exp=010", coalesce_o, allocate_o, dly_clr_valid));
    // R1 R2: first write at 0 is contiguous, no pulse
    send(1, 1, 1, 0, 32'd0,  8'd64, 32'd0,  "R1");
    send(1, 1, 1, 0, 32'd64, 8'd64, 32'd64, "R3_at_limit");   // count 128
    // R8: ignored requests
    send(1, 1, 0, 0, 32'h500, 8'd4, 32'h500, "R8_uncacheable");
    send(1, 0, 1, 0, 32'h600, 8'd4, 32'h600, "R8_read");
    send(1, 1, 1, 0, 32'd128, 8'd1, 32'd128, "R3_past_limit"); // 129 coalesce
    send(1, 1, 1, 0, 32'd129, 8'd63, 32'd128, "R2");           // 192
    a = 32'd192;
    for (int i = 0; i < 9; i++) begin                           // reaches 768
      send(1, 1, 1, 0, a, 8'd64, a, "R4_at_limit");
      a += 64;
    end
    send(1, 1, 1, 0, a, 8'd1, a, "R4_past_limit");              // 769 no-alloc
    a += 1;
    send(1, 1, 1, 0, a, 8'd255, a, "R5"); a += 255;
    send(0, 0, 0, 0, 32'd0, 8'd0, 32'd0, "R7_idle");
    send(1, 1, 1, 0, a, 8'd200, a, "R5_hold"); a += 200;
    // R6: break
    send(1, 1, 1, 0, 32'h1000, 8'd64, 32'h1000, "R6_break");
    send(0, 0, 0, 0, 32'd0, 8'd0, 32'd0, "R6_pulse_end");
    send(1, 1, 1, 0, 32'h1040, 8'd65, 32'h1040, "R6_reload");   // 129 coalesce
    send(1, 1, 1, 0, 32'h2000, 8'd255, 32'h2000, "R6_big_break");// ALLOC count 255
    send(1, 1, 1, 0, 32'h20FF, 8'd1, 32'h20C0, "R4_one_step");   // 256 -> coalesce
    // R9: clear overrides a simultaneous break
    send(1, 1, 1, 1, 32'h9000, 8'd8, 32'h9000, "R9_clear");
    send(1, 1, 1, 0, 32'd0, 8'd129, 32'd0, "R9_next_zero");      // contiguous, 129
    send(1, 0, 0, 1, 32'd0, 8'd0, 32'd0, "R9_clear_idle");
    send(1, 1, 1, 0, 32'd0, 8'd128, 32'd0, "R9_count_zero");     // 128 stays alloc
    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R10", $sformatf("queue act=%0d exp=0", q.size()));
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule